// File: doc/BRIEF.md
# Programmable Sync Pulse Generator

This block keeps a free-running binary counter and raises a one-cycle terminal-count pulse each time the counter completes a period. Software picks one of four power-of-two periods. An external sync input can pull the counter back to zero, so several copies of the block can share one timing reference. The low counter bits are brought out as a ramp-shaped stream of test samples for diagnostic paths.

A separate sync output carries one of several sources and is always registered. The sources are the rising edge of the external sync input delayed by one clock, the terminal-count pulse, or a single pulse produced when a software trigger bit goes high. The block runs in one clock domain and does not drive any clear or reset of neighbouring logic.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `sample_o` = 0, `tc_o` = 0 and `sync_o` = 0.
- R2: Outside reset and reload, the counter advances by one on each clock and wraps at 2^CNT_W. `sample_o` is its low SAMP_W bits.
- R3: `period_sel` chooses the period as 00 = 2^PER_EXP[0], 01 = 2^PER_EXP[1], 10 = 2^PER_EXP[2] and 11 = 2^PER_EXP[3] (defaults 8, 12, 16, 20). `tc_o` is high for one cycle, in the cycle after an edge at which the selected low counter bits were all ones.
- R4: When `resync_en` and `sync_in` are both high at an edge, the counter is zero in the next cycle, so the next terminal count comes a full period later. With `resync_en` low, `sync_in` leaves the count unchanged.
- R5: With `out_src` = 00, `sync_o` is high for exactly one cycle, in the cycle after an edge where `sync_in` was high and had been low at the edge before.
- R6: With `out_src` = 01, `sync_o` follows the terminal-count pulse and is high in the same cycles as `tc_o`.
- R7: With `out_src` = 10, a rising edge of `shot_trig` produces one pulse on `sync_o` in the next cycle. No further pulse comes until the trigger has gone low and high again.
- R8: With `out_src` = 11, `sync_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External sync input |
| period_sel | input | 2 | Terminal-count period select |
| resync_en | input | 1 | Allow sync_in to reload the counter |
| out_src | input | 2 | Source for sync_o |
| shot_trig | input | 1 | Software trigger for the one-shot |
| tc_o | output | 1 | Terminal-count pulse |
| sync_o | output | 1 | Selected sync output, one cycle wide |
| sample_o | output | SAMP_W | Low counter bits as test samples |

## Verification
The assertions assume that `sync_in` and `shot_trig` are low while reset is applied, so the edge detectors come out of reset in a known state. They also assume that each period exponent is at least one, so that two terminal counts cannot fall in adjacent cycles. The stimulus drives every input low during reset and changes inputs only on the falling clock edge. The bench shrinks the counter and the period exponents through parameters, so that all four periods complete more than one full cycle inside the run.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
  typedef enum logic [1:0] {
    SRC_EDGE = 2'b00,
    SRC_TC   = 2'b01,
    SRC_SHOT = 2'b10,
    SRC_OFF  = 2'b11
  } sync_src_e;
endpackage

// File: rtl/sync_cnt.sv
module sync_cnt #(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned PER_EXP [4] = '{8, 12, 16, 20}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [1:0]       psel,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_next_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mask_tbl [4];

  // One low-bit mask per period choice
  for (genvar g = 0; g < 4; g++) begin : g_mask
    localparam logic [CNT_W-1:0] MASK_G = ALL_ONES >> (CNT_W - PER_EXP[g]);
    assign mask_tbl[g] = MASK_G;
  end

  logic [CNT_W-1:0] cnt_q;

  assign tc_next_o = &(cnt_q | ~mask_tbl[psel]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc_o  <= 1'b0;
    end else begin
      tc_o  <= tc_next_o;
      cnt_q <= reload ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_rise.sv
module sync_rise (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= d;
  end

  assign rise_o = d & ~d_q;
endmodule

// File: rtl/sync_outsel.sv
module sync_outsel
  import sync_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sync_src_e src,
  input  logic      edge_in,
  input  logic      tc_in,
  input  logic      shot_in,
  output logic      sync_o
);
  logic pick;

  always_comb begin
    unique case (src)
      SRC_EDGE: pick = edge_in;
      SRC_TC:   pick = tc_in;
      SRC_SHOT: pick = shot_in;
      default:  pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sync_o <= 1'b0;
    else     sync_o <= pick;
  end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_gen_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SAMP_W      = 12,
  parameter int unsigned PER_EXP [4] = '{8, 12, 16, 20}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic [1:0]        period_sel,
  input  logic              resync_en,
  input  logic [1:0]        out_src,
  input  logic              shot_trig,
  output logic              tc_o,
  output logic              sync_o,
  output logic [SAMP_W-1:0] sample_o
);
  logic [CNT_W-1:0] cnt;
  logic             tc_next;
  logic             sync_rise_w;
  logic             shot_rise_w;
  logic             reload;

  assign reload = resync_en & sync_in;

  sync_cnt #(.CNT_W(CNT_W), .PER_EXP(PER_EXP)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .reload    (reload),
    .psel      (period_sel),
    .cnt_o     (cnt),
    .tc_next_o (tc_next),
    .tc_o      (tc_o)
  );

  sync_rise u_sync_edge (
    .clk    (clk),
    .rst    (rst),
    .d      (sync_in),
    .rise_o (sync_rise_w)
  );

  sync_rise u_shot_edge (
    .clk    (clk),
    .rst    (rst),
    .d      (shot_trig),
    .rise_o (shot_rise_w)
  );

  sync_outsel u_sel (
    .clk     (clk),
    .rst     (rst),
    .src     (sync_src_e'(out_src)),
    .edge_in (sync_rise_w),
    .tc_in   (tc_next),
    .shot_in (shot_rise_w),
    .sync_o  (sync_o)
  );

  assign sample_o = cnt[SAMP_W-1:0];
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk
  import sync_gen_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SAMP_W      = 12,
  parameter int unsigned PER_EXP [4] = '{8, 12, 16, 20}
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_in,
  input logic [1:0]        period_sel,
  input logic              resync_en,
  input logic [1:0]        out_src,
  input logic              shot_trig,
  input logic              tc_o,
  input logic              sync_o,
  input logic [SAMP_W-1:0] sample_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sample_o == '0) && !tc_o && !sync_o);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !(resync_en && sync_in) |=> sample_o == SAMP_W'($past(sample_o) + 1'b1));

  p_tc_single_r3: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> !tc_o);

  p_reload_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (resync_en && sync_in) |=> sample_o == '0);

  p_edge_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_EDGE && sync_in && !$past(sync_in) && !$past(rst)) |=> sync_o);

  p_edge_width_r5: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_EDGE && sync_o) |=> !sync_o);

  p_tc_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_TC) |=> sync_o == tc_o);

  p_shot_fire_r7: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_SHOT && shot_trig && !$past(shot_trig) && !$past(rst)) |=> sync_o);

  p_shot_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_SHOT && shot_trig && $past(shot_trig)) |=> !sync_o);

  p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
    (out_src == SRC_OFF) |=> !sync_o);
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(
  .CNT_W(CNT_W), .SAMP_W(SAMP_W), .PER_EXP(PER_EXP)
) u_chk (.*);

// File: tb/sync_pulse_gen_test.sv
`timescale 1ns/1ps
module sync_pulse_gen_test;
  localparam int unsigned CW = 12;
  localparam int unsigned SW = 6;
  localparam int unsigned PE [4] = '{3, 5, 8, 12};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          sync_in = 1'b0;
  logic [1:0]    period_sel = 2'b00;
  logic          resync_en = 1'b0;
  logic [1:0]    out_src = 2'b01;
  logic          shot_trig = 1'b0;
  logic          tc_o, sync_o;
  logic [SW-1:0] sample_o;

  sync_pulse_gen #(.CNT_W(CW), .SAMP_W(SW), .PER_EXP(PE)) uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .period_sel(period_sel),
    .resync_en(resync_en), .out_src(out_src), .shot_trig(shot_trig),
    .tc_o(tc_o), .sync_o(sync_o), .sample_o(sample_o)
  );

  typedef struct {
    logic          tc;
    logic          so;
    logic [SW-1:0] smp;
    string         stag;
    string         otag;
    string         ttag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: pushes one expected item per clock edge
  logic [CW-1:0] mcnt = '0;
  logic          ps = 1'b0, pt = 1'b0;
  always @(posedge clk) begin
    exp_t e;
    logic [CW-1:0] msk;
    logic tcn;
    if (rst) begin
      mcnt = '0; ps = 1'b0; pt = 1'b0;
      e.tc = 1'b0; e.so = 1'b0; e.smp = '0;
      e.stag = "R1"; e.otag = "R1"; e.ttag = "R1";
    end else begin
      msk = CW'((64'd1 << PE[period_sel]) - 64'd1);
      tcn = ((mcnt & msk) == msk);
      case (out_src)
        2'b00: begin e.so = sync_in & ~ps;   e.otag = "R5"; end
        2'b01: begin e.so = tcn;             e.otag = "R6"; end
        2'b10: begin e.so = shot_trig & ~pt; e.otag = "R7"; end
        default: begin e.so = 1'b0;          e.otag = "R8"; end
      endcase
      e.stag = sync_in ? "R4" : "R2";
      e.ttag = "R3";
      mcnt = (sync_in && resync_en) ? '0 : mcnt + 1'b1;
      e.tc  = tcn;
      e.smp = mcnt[SW-1:0];
      ps = sync_in;
      pt = shot_trig;
    end
    q.push_back(e);
  end

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Monitor: compares outputs away from the active edge
  always @(negedge clk) begin
    if (!done && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(32'(tc_o), 32'(e.tc), e.ttag);
      check(32'(sync_o), 32'(e.so), e.otag);
      check(32'(sample_o), 32'(e.smp), e.stag);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    cyc(4);
    rst = 1'b0;
    // R3, R6: every period with terminal count on the output
    out_src = 2'b01;
    for (int p = 0; p < 4; p++) begin
      period_sel = 2'(p);
      cyc(2 * (1 << PE[p]) + 7);
    end
    // R4: reload with enable, and held sync
    period_sel = 2'b01;
    resync_en = 1'b1;
    cyc(5);  sync_in = 1'b1; cyc(1); sync_in = 1'b0;
    cyc(40); sync_in = 1'b1; cyc(3); sync_in = 1'b0;
    cyc(70);
    // R4: sync ignored when reload disabled
    resync_en = 1'b0;
    sync_in = 1'b1; cyc(2); sync_in = 1'b0;
    cyc(20);
    // R5: delayed edge of sync input, short and long pulses
    out_src = 2'b00;
    cyc(3); sync_in = 1'b1; cyc(1); sync_in = 1'b0;
    cyc(5); sync_in = 1'b1; cyc(6); sync_in = 1'b0;
    resync_en = 1'b1;
    cyc(4); sync_in = 1'b1; cyc(2); sync_in = 1'b0;
    resync_en = 1'b0;
    cyc(5);
    // R7: one-shot fires once per rising edge
    out_src = 2'b10;
    cyc(3); shot_trig = 1'b1; cyc(10); shot_trig = 1'b0;
    cyc(4); shot_trig = 1'b1; cyc(1);  shot_trig = 1'b0;
    cyc(6);
    // R8: output held low with every source active
    out_src = 2'b11;
    period_sel = 2'b00;
    shot_trig = 1'b1; sync_in = 1'b1; cyc(2);
    shot_trig = 1'b0; sync_in = 1'b0; cyc(30);
    // R1: reset again mid-run
    rst = 1'b1; cyc(3); rst = 1'b0;
    out_src = 2'b01;
    cyc(20);
    finish_run();
  end
endmodule